// File: doc/BRIEF.md
# Bus Parity Control Unit

This block handles the parity bit of an 8-bit parallel peripheral bus. On the send side it computes the parity bit for the outgoing byte. A sense control normally produces odd parity. When the sense control is flipped, the block produces even parity, so a byte with deliberately wrong parity can be sent to exercise the far end's error recovery. On the receive side it checks each byte presented with the receive-valid strobe against odd parity, but only while checking is enabled.

A detected error does three things. It sets a sticky status flag, which software clears with a one-cycle pulse. It can request an interrupt when the interrupt enable is set. It can also raise a role-dependent request. When the block acts as initiator, the request is attention, and only if attention-on-error is enabled. When the block acts as target, the request is halt, unless halt has been disabled. Both requests are registered and are held until an acknowledge pulse.

Two small state machines hold the state:
- The status machine has two states. FLAG_CLEAR goes to FLAG_SET on an error. FLAG_SET goes back to FLAG_CLEAR on a clear pulse with no error in that cycle.
- The request machine has four states: REQ_IDLE, REQ_ATN, REQ_HALT and REQ_BOTH. From any state it moves to the state that holds the union of two sets: the requests newly raised by an error, and the requests still held because no acknowledge arrived. An acknowledge with no new error returns it to REQ_IDLE.

Top module: `bus_parity_ctl`

## Requirements
- R1: With `even_sense` = 0, `tx_par` makes the total count of ones in `tx_data` plus `tx_par` odd. This is combinational.
- R2: With `even_sense` = 1, `tx_par` makes that total count even. This produces a deliberately bad byte.
- R3: A receive error exists at a clock edge when `rx_valid` = 1, `chk_en` = 1, and `rx_data` plus `rx_par` hold an even number of ones. After that edge, `perr_stat` reads 1.
- R4: An edge with `rx_valid` = 0 or `chk_en` = 0 is never an error, whatever the data. Such an edge sets no status and raises no request.
- R5: `perr_stat` stays at 1 until an edge with `perr_clr` = 1. After that edge it reads 0, provided that edge carries no error.
- R6: When an error and `perr_clr` arrive at the same edge, `perr_stat` reads 1 afterwards.
- R7: Consider an error edge with `role_tgt` = 0 (initiator) and `atn_on_err` = 1. After that edge `atn_req` reads 1, and it stays at 1 until an edge with `req_ack` = 1. `atn_req` is never raised in the target role or when `atn_on_err` = 0.
- R8: Consider an error edge with `role_tgt` = 1 (target). If `no_halt` = 0, `halt_req` reads 1 after that edge and stays at 1 until an edge with `req_ack` = 1. If `no_halt` = 1, the edge raises no halt.
- R9: `halt_req` is never raised in the initiator role, whatever `no_halt` is.
- R10: `irq_req` equals `perr_stat` AND `perr_irq_en` at all times. Both are modelled as bit 0 of their registers.
- R11: An edge with `rst_n` = 0 (synchronous, active low) leaves `perr_stat`, `atn_req`, `halt_req` and `irq_req` all at 0. No error is taken at that edge.
- R12: When an error that raises a request arrives at the same edge as `req_ack`, that request reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Outgoing byte |
| tx_par | output | 1 | Generated parity bit for tx_data |
| rx_data | input | 8 | Incoming byte |
| rx_par | input | 1 | Incoming parity bit |
| rx_valid | input | 1 | Incoming byte and parity are sampled at this edge |
| role_tgt | input | 1 | 0 = initiator, 1 = target |
| chk_en | input | 1 | Enables receive parity checking |
| even_sense | input | 1 | 1 = generate even (bad) parity |
| atn_on_err | input | 1 | Raise attention on error in initiator role |
| no_halt | input | 1 | Suppress halt on error in target role |
| perr_irq_en | input | 1 | Parity error interrupt enable |
| perr_clr | input | 1 | Pulse that clears the status flag |
| req_ack | input | 1 | Pulse that drops held attention/halt requests |
| atn_req | output | 1 | Attention request |
| halt_req | output | 1 | Halt request |
| irq_req | output | 1 | Interrupt request |
| perr_stat | output | 1 | Sticky parity error status |

## Verification
All machine state is visible at the ports. The status machine drives `perr_stat` directly, and the request machine drives `atn_req` and `halt_req`. A wrong state therefore shows on the edge after the faulty transition, as a flag that fails to set, fails to clear, or shows up in the wrong role. The bench compares every output against a reference model after every edge, so a divergence is reported in the cycle where it first appears. The same-edge collisions, error with clear and error with acknowledge, are driven on purpose, because a priority mistake shows only there.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'b00,
        REQ_ATN  = 2'b01,
        REQ_HALT = 2'b10,
        REQ_BOTH = 2'b11
    } req_state_t;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;
endpackage

// File: rtl/bp_tx_gen.sv
module bp_tx_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         even_sense,
    output logic         par
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data;
        // odd sense: bit completes an odd total; even sense: an even total
        par = even_sense ? ones_odd : ~ones_odd;
    end
endmodule

// File: rtl/bp_rx_chk.sv
module bp_rx_chk #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic [W-1:0] data,
    input  logic         par,
    input  logic         valid,
    input  logic         chk_en,
    output logic         err
);
    logic total_odd;

    always_comb begin
        total_odd = ^{data, par};
        err       = rst_n && valid && chk_en && !total_odd;
    end
endmodule

// File: rtl/bp_flag_fsm.sv
module bp_flag_fsm
    import bus_parity_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic clr,
    input  logic irq_en,
    output logic stat,
    output logic irq
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (err) state_d = FLAG_SET;
            FLAG_SET:   if (clr && !err) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        stat = (state_q == FLAG_SET);
        irq  = stat && irq_en;
    end
endmodule

// File: rtl/bp_req_fsm.sv
module bp_req_fsm
    import bus_parity_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic role_tgt,
    input  logic atn_on_err,
    input  logic no_halt,
    input  logic ack,
    output logic atn,
    output logic halt
);
    req_state_t state_q, state_d;
    logic held_atn, held_halt, new_atn, new_halt, want_atn, want_halt;

    always_comb begin
        held_atn  = (state_q == REQ_ATN  || state_q == REQ_BOTH) && !ack;
        held_halt = (state_q == REQ_HALT || state_q == REQ_BOTH) && !ack;
        new_atn   = err && !role_tgt && atn_on_err;
        new_halt  = err &&  role_tgt && !no_halt;
        want_atn  = held_atn  || new_atn;
        want_halt = held_halt || new_halt;
        unique case ({want_halt, want_atn})
            2'b00:   state_d = REQ_IDLE;
            2'b01:   state_d = REQ_ATN;
            2'b10:   state_d = REQ_HALT;
            default: state_d = REQ_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE: begin atn = 1'b0; halt = 1'b0; end
            REQ_ATN:  begin atn = 1'b1; halt = 1'b0; end
            REQ_HALT: begin atn = 1'b0; halt = 1'b1; end
            default:  begin atn = 1'b1; halt = 1'b1; end
        endcase
    end
endmodule

// File: rtl/bus_parity_ctl.sv
module bus_parity_ctl
    import bus_parity_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tx_data,
    output logic         tx_par,
    input  logic [W-1:0] rx_data,
    input  logic         rx_par,
    input  logic         rx_valid,
    input  logic         role_tgt,
    input  logic         chk_en,
    input  logic         even_sense,
    input  logic         atn_on_err,
    input  logic         no_halt,
    input  logic         perr_irq_en,
    input  logic         perr_clr,
    input  logic         req_ack,
    output logic         atn_req,
    output logic         halt_req,
    output logic         irq_req,
    output logic         perr_stat
);
    logic rx_err;

    bp_tx_gen #(.W(W)) u_tx (
        .data       (tx_data),
        .even_sense (even_sense),
        .par        (tx_par)
    );

    bp_rx_chk #(.W(W)) u_rx (
        .rst_n  (rst_n),
        .data   (rx_data),
        .par    (rx_par),
        .valid  (rx_valid),
        .chk_en (chk_en),
        .err    (rx_err)
    );

    bp_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .err    (rx_err),
        .clr    (perr_clr),
        .irq_en (perr_irq_en),
        .stat   (perr_stat),
        .irq    (irq_req)
    );

    bp_req_fsm u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .err        (rx_err),
        .role_tgt   (role_tgt),
        .atn_on_err (atn_on_err),
        .no_halt    (no_halt),
        .ack        (req_ack),
        .atn        (atn_req),
        .halt       (halt_req)
    );
endmodule

// File: rtl/bus_parity_chk.sv
module bus_parity_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tx_data,
    input logic         tx_par,
    input logic [W-1:0] rx_data,
    input logic         rx_par,
    input logic         rx_valid,
    input logic         role_tgt,
    input logic         chk_en,
    input logic         even_sense,
    input logic         atn_on_err,
    input logic         no_halt,
    input logic         perr_irq_en,
    input logic         perr_clr,
    input logic         req_ack,
    input logic         atn_req,
    input logic         halt_req,
    input logic         irq_req,
    input logic         perr_stat
);
    logic bad;
    assign bad = rx_valid && chk_en && !(^{rx_data, rx_par});

    a_r1_tx_odd: assert property (@(posedge clk) disable iff (!rst_n)
        !even_sense |-> (^{tx_data, tx_par}) == 1'b1);
    a_r2_tx_even: assert property (@(posedge clk) disable iff (!rst_n)
        even_sense |-> (^{tx_data, tx_par}) == 1'b0);
    a_r3_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> perr_stat);
    a_r4_no_check: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_stat && !bad) |=> !perr_stat);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_clr && !bad) |=> !perr_stat);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_stat && !perr_clr) |=> perr_stat);
    a_r7_atn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !role_tgt && atn_on_err) |=> atn_req);
    a_r7_atn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (atn_req && !req_ack) |=> atn_req);
    a_r7_atn_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!atn_req && !(bad && !role_tgt && atn_on_err)) |=> !atn_req);
    a_r8_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && role_tgt && !no_halt) |=> halt_req);
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !req_ack) |=> halt_req);
    a_r9_halt_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && !(bad && role_tgt && !no_halt)) |=> !halt_req);
    a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (perr_stat && perr_irq_en));
endmodule

bind bus_parity_ctl bus_parity_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bus_parity_ctl.sv
module tb_bus_parity_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] tx_data, rx_data;
    logic       tx_par, rx_par, rx_valid, role_tgt, chk_en, even_sense;
    logic       atn_on_err, no_halt, perr_irq_en, perr_clr, req_ack;
    logic       atn_req, halt_req, irq_req, perr_stat;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic m_stat, m_atn, m_halt;

    always #10 clk = ~clk;

    bus_parity_ctl dut (.*);

    function automatic logic exp_tx(input logic [7:0] d, input logic ev);
        return ev ? ^d : ~^d;
    endfunction

    function automatic logic rx_error(input logic v, input logic en,
                                      input logic [7:0] d, input logic p);
        return v && en && ((^{d, p}) == 1'b0);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        rst_n = 1'b1; tx_data = 8'h00; rx_data = 8'h00; rx_par = 1'b1;
        rx_valid = 1'b0; role_tgt = 1'b0; chk_en = 1'b1; even_sense = 1'b0;
        atn_on_err = 1'b0; no_halt = 1'b0; perr_irq_en = 1'b0;
        perr_clr = 1'b0; req_ack = 1'b0;
    endtask

    // advance one edge, update the model, compare all outputs
    task automatic step();
        logic e;
        #1;
        chk(even_sense ? "R2 tx parity" : "R1 tx parity", tx_par, exp_tx(tx_data, even_sense));
        e = rx_error(rx_valid, chk_en, rx_data, rx_par);
        if (!rst_n) begin
            m_stat = 1'b0; m_atn = 1'b0; m_halt = 1'b0;
        end else begin
            m_stat = e || (m_stat && !perr_clr);
            m_atn  = (e && !role_tgt && atn_on_err) || (m_atn && !req_ack);
            m_halt = (e && role_tgt && !no_halt) || (m_halt && !req_ack);
        end
        @(posedge clk);
        #2;
        chk("R3/R5 perr_stat", perr_stat, m_stat);
        chk("R7 atn_req", atn_req, m_atn);
        chk("R8/R9 halt_req", halt_req, m_halt);
        chk("R10 irq_req", irq_req, m_stat && perr_irq_en);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5C51));
        idle_inputs();
        m_stat = 1'b0; m_atn = 1'b0; m_halt = 1'b0;
        @(negedge clk);

        // R11: reset with an error and all enables present
        rst_n = 1'b0; rx_valid = 1'b1; rx_data = 8'h03; rx_par = 1'b0;
        atn_on_err = 1'b1; perr_irq_en = 1'b1;
        step(); step();
        chk("R11 reset stat", perr_stat, 1'b0);
        chk("R11 reset atn", atn_req, 1'b0);
        chk("R11 reset irq", irq_req, 1'b0);
        idle_inputs();

        // R4: bad byte with checking disabled, then bad byte without strobe
        chk_en = 1'b0; rx_valid = 1'b1; rx_data = 8'h01; rx_par = 1'b1;
        atn_on_err = 1'b1; role_tgt = 1'b0;
        step();
        chk("R4 chk_en off", perr_stat, 1'b0);
        chk_en = 1'b1; rx_valid = 1'b0;
        step();
        chk("R4 no strobe", atn_req, 1'b0);

        // R3/R7: bad byte in initiator role
        rx_valid = 1'b1; rx_data = 8'hF0; rx_par = 1'b0;
        step();
        chk("R3 error sets", perr_stat, 1'b1);
        chk("R7 atn raised", atn_req, 1'b1);
        rx_valid = 1'b0; step();
        chk("R7 atn held", atn_req, 1'b1);

        // R6 and R12: new error with clear and ack at the same edge
        rx_valid = 1'b1; perr_clr = 1'b1; req_ack = 1'b1;
        step();
        chk("R6 error beats clear", perr_stat, 1'b1);
        chk("R12 error beats ack", atn_req, 1'b1);
        rx_valid = 1'b0; step();
        chk("R5 cleared", perr_stat, 1'b0);
        chk("R7 acked", atn_req, 1'b0);
        perr_clr = 1'b0; req_ack = 1'b0;

        // R9: no_halt clear in initiator role never halts
        no_halt = 1'b0; atn_on_err = 1'b0; rx_valid = 1'b1;
        step();
        chk("R9 no halt initiator", halt_req, 1'b0);
        chk("R7 atn off when disabled", atn_req, 1'b0);

        // R8: target role, halt suppressed then allowed
        role_tgt = 1'b1; no_halt = 1'b1; atn_on_err = 1'b1;
        step();
        chk("R8 halt suppressed", halt_req, 1'b0);
        chk("R7 no atn in target", atn_req, 1'b0);
        no_halt = 1'b0; step();
        chk("R8 halt raised", halt_req, 1'b1);
        rx_valid = 1'b0; perr_irq_en = 1'b1; step();
        chk("R10 irq with enable", irq_req, 1'b1);
        req_ack = 1'b1; perr_clr = 1'b1; step();
        req_ack = 1'b0; perr_clr = 1'b0;

        // R2: deliberate bad parity
        even_sense = 1'b1; tx_data = 8'h07; step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tx_data     = 8'($urandom);
            rx_data     = 8'($urandom);
            rx_par      = 1'($urandom);
            rx_valid    = ($urandom % 2) == 0;
            chk_en      = ($urandom % 4) != 0;
            role_tgt    = 1'($urandom);
            even_sense  = 1'($urandom);
            atn_on_err  = 1'($urandom);
            no_halt     = ($urandom % 3) == 0;
            perr_irq_en = 1'($urandom);
            perr_clr    = ($urandom % 8) == 0;
            req_ack     = ($urandom % 6) == 0;
            rst_n       = ($urandom % 200) != 0;
            step();
        end
        finish_run();
    end
endmodule